// File: doc/BRIEF.md
# Strided Stream Write Queue

This block is one write channel of a stream engine that sits beside the data cache. Software configures it with a starting byte address, an element stride, an element width and, if wanted, an element count. The processor then pushes one element at a time. The block works out the byte address of each element and keeps element and address together in a small internal buffer. It writes the buffer out to memory in bursts, so that elements falling in the same memory page leave back to back instead of one at a time.

A small flush controller decides when the buffer drains. A drain starts when the buffer reaches a fill threshold. It also starts when the address of the next element to be pushed lies in a different page from the oldest buffered element, or when the stream has ended. A stream ends when its count is used up or when the explicit close input is pulsed. Each burst stays inside one page and is capped at a parameterised beat count. A completion flag tells software that every element it pushed has been acknowledged by memory.

Top module: `stride_wr_queue`

## Requirements
- R1: After reset, push_ready, mem_valid and done are all low until a stream is configured.
- R2: Element k of a stream is written to byte address base + k * stride * B, where B is 1, 4 or 8 for size code 0, 1 or 2. Every beat carries the configured size code on mem_size.
- R3: Beats carry the pushed data values in the order in which they were pushed.
- R4: While the buffer holds fewer than THRESH elements, the next push address stays in the oldest element's page and the stream is still open, no beat is issued. Reaching THRESH elements starts a drain.
- R5: A page is the byte address shifted right by PAGE_W. When the page of the next push address differs from the page of the oldest buffered element, a drain starts without waiting for the threshold.
- R6: mem_last marks the final beat of a burst. A burst ends when the buffer would empty, when the next buffered element lies in another page, or after MAX_BURST beats. While mem_valid is high and mem_ready low, mem_addr and mem_data hold.
- R7: push_ready is low whenever DEPTH elements are buffered. A push offered while push_ready is low is not taken and produces no beat.
- R8: In counted mode, once the configured number of elements has been pushed, push_ready drops and the remaining buffered elements drain below the threshold.
- R9: A pulse on stream_close ends an uncounted stream. push_ready drops and the buffered elements drain below the threshold.
- R10: done rises only after the stream has ended and every pushed element has been acknowledged on mem_ack. It stays low while any element is buffered or unacknowledged, and a new configuration clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Load a new stream configuration |
| cfg_base | input | AW | Byte address of the first element |
| cfg_stride | input | AW | Distance between elements, in elements |
| cfg_size | input | 2 | Element width code: 0 byte, 1 four bytes, 2 eight bytes |
| cfg_counted | input | 1 | Stream ends after cfg_len elements |
| cfg_len | input | LEN_W | Element count for counted mode |
| stream_close | input | 1 | End the stream now and force the drain |
| push_valid | input | 1 | Processor offers an element |
| push_data | input | DW | Element value |
| push_ready | output | 1 | Element is taken on this edge if push_valid |
| mem_valid | output | 1 | Write beat is presented |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | AW | Byte address of the beat |
| mem_data | output | DW | Data of the beat |
| mem_size | output | 2 | Size code of the beat |
| mem_last | output | 1 | Final beat of the current burst |
| mem_ack | input | 1 | One element's write has completed |
| done | output | 1 | Stream ended and all elements acknowledged |

## Verification
A wrong buffer pointer shows up on the beats that follow it as a repeated or skipped data value, or as an address off by one stride. It appears no later than the drain after the fault. A wrong page or threshold decision shows within a few cycles of the triggering push: a beat appears too early, or no beat appears although one is due. A wrong count of outstanding writes shows as done rising while a beat is still unacknowledged, or never rising, so the bench records done at every beat and waits for it after the final acknowledge.

// File: rtl/swq_pkg.sv
package swq_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE  = 2'd0,
    ESZ_WORD  = 2'd1,
    ESZ_DWORD = 2'd2,
    ESZ_RSVD  = 2'd3
  } esize_e;

  typedef enum logic {
    FL_IDLE  = 1'b0,
    FL_BURST = 1'b1
  } flush_st_e;

  // log2 of the element width in bytes
  function automatic logic [1:0] esize_shift(input logic [1:0] code);
    esize_e c;
    c = esize_e'(code);
    case (c)
      ESZ_BYTE: esize_shift = 2'd0;
      ESZ_WORD: esize_shift = 2'd2;
      default:  esize_shift = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/swq_addr_gen.sv
module swq_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] cur_addr
);
  import swq_pkg::*;

  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] stb_q, stb_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    cur_d = cur_q;
    stb_d = stb_q;
    if (load) begin
      cur_d = base;
      stb_d = stride << esize_shift(size_code);
    end else if (step) begin
      cur_d = cur_q + stb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      stb_q <= '0;
    end else if (en) begin
      cur_q <= cur_d;
      stb_q <= stb_d;
    end
  end

  assign cur_addr = cur_q;
endmodule

// File: rtl/swq_fifo.sv
module swq_fifo #(
  parameter int DW    = 64,
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  output logic [DW-1:0] head_data,
  output logic [AW-1:0] head_addr,
  output logic [AW-1:0] head1_addr,
  output logic [CW-1:0] count
);
  logic [DW-1:0] data_mem [DEPTH];
  logic [AW-1:0] addr_mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, rd_nx;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_nx = bump(rd_q);

  always_comb begin
    wr_d  = wr_en ? bump(wr_q) : wr_q;
    rd_d  = rd_en ? rd_nx : rd_q;
    cnt_d = cnt_q;
    if (wr_en && !rd_en)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && rd_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en)           wr_q  <= wr_d;
      if (rd_en)           rd_q  <= rd_d;
      if (wr_en ^ rd_en)   cnt_q <= cnt_d;
    end
  end

  // storage: one enable per entry, no reset needed on payload
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_q == PW'(e));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        data_mem[e] <= wr_data;
        addr_mem[e] <= wr_addr;
      end
    end
  end

  assign head_data  = data_mem[rd_q];
  assign head_addr  = addr_mem[rd_q];
  assign head1_addr = addr_mem[rd_nx];
  assign count      = cnt_q;
endmodule

// File: rtl/swq_flush_ctl.sv
module swq_flush_ctl #(
  parameter int AW        = 32,
  parameter int PAGE_W    = 11,
  parameter int THRESH    = 6,
  parameter int MAX_BURST = 256,
  parameter int CW        = 4,
  localparam int BW       = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] head_addr,
  input  logic [AW-1:0] head1_addr,
  input  logic [AW-1:0] next_addr,
  input  logic          stream_live,
  input  logic          stream_ended,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_last,
  output logic          pop
);
  import swq_pkg::*;

  flush_st_e     st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          have, trig_fill, trig_page, trig_end, trig;
  logic          brk_page, brk_cap, brk_empty;

  assign have      = (count != '0);
  assign trig_fill = (count >= CW'(THRESH));
  assign trig_page = stream_live && have &&
                     (next_addr[AW-1:PAGE_W] != head_addr[AW-1:PAGE_W]);
  assign trig_end  = stream_ended && have;
  assign trig      = trig_fill | trig_page | trig_end;

  assign brk_empty = (count == CW'(1));
  assign brk_page  = (head1_addr[AW-1:PAGE_W] != head_addr[AW-1:PAGE_W]);
  assign brk_cap   = (beat_q == BW'(MAX_BURST - 1));

  assign mem_valid = (st_q == FL_BURST);
  assign mem_last  = mem_valid && (brk_empty || brk_page || brk_cap);
  assign pop       = mem_valid && mem_ready;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    case (st_q)
      FL_IDLE: begin
        if (trig) begin
          st_d   = FL_BURST;
          beat_d = '0;
        end
      end
      default: begin
        if (pop) begin
          if (mem_last) st_d = FL_IDLE;
          else          beat_d = beat_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FL_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/stride_wr_queue.sv
module stride_wr_queue #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int DEPTH     = 8,
  parameter int THRESH    = 6,
  parameter int PAGE_W    = 11,
  parameter int MAX_BURST = 256,
  parameter int LEN_W     = 16,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int PEND_W   = CW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_stride,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_counted,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             stream_close,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  output logic             push_ready,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  output logic [1:0]       mem_size,
  output logic             mem_last,
  input  logic             mem_ack,
  output logic             done
);
  logic             live_q, live_d, started_q, started_d, counted_q, counted_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [1:0]       size_q, size_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic             push_fire, pop, ended, ack_ok;
  logic [AW-1:0]    next_addr, head1_addr;
  logic [CW-1:0]    buf_count;

  assign push_ready = live_q && (buf_count != CW'(DEPTH));
  assign push_fire  = push_valid && push_ready;
  assign ended      = started_q && !live_q;
  assign ack_ok     = mem_ack && (pend_q != '0);

  swq_addr_gen #(.AW(AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(cfg_start), .step(push_fire),
    .base(cfg_base), .stride(cfg_stride), .size_code(cfg_size),
    .cur_addr(next_addr)
  );

  swq_fifo #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(push_fire), .wr_data(push_data),
    .wr_addr(next_addr), .rd_en(pop), .head_data(mem_data),
    .head_addr(mem_addr), .head1_addr(head1_addr), .count(buf_count)
  );

  swq_flush_ctl #(
    .AW(AW), .PAGE_W(PAGE_W), .THRESH(THRESH),
    .MAX_BURST(MAX_BURST), .CW(CW)
  ) u_flush (
    .clk(clk), .rst_n(rst_n), .count(buf_count), .head_addr(mem_addr),
    .head1_addr(head1_addr), .next_addr(next_addr), .stream_live(live_q),
    .stream_ended(ended), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .mem_last(mem_last), .pop(pop)
  );

  always_comb begin
    live_d    = live_q;
    started_d = started_q;
    counted_d = counted_q;
    remain_d  = remain_q;
    size_d    = size_q;
    if (cfg_start) begin
      live_d    = !(cfg_counted && (cfg_len == '0));
      started_d = 1'b1;
      counted_d = cfg_counted;
      remain_d  = cfg_len;
      size_d    = cfg_size;
    end else begin
      if (push_fire && counted_q) remain_d = remain_q - 1'b1;
      if (stream_close || (push_fire && counted_q && remain_q == LEN_W'(1)))
        live_d = 1'b0;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (push_fire && !ack_ok)      pend_d = pend_q + 1'b1;
    else if (!push_fire && ack_ok) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= 1'b0;
      started_q <= 1'b0;
      counted_q <= 1'b0;
      remain_q  <= '0;
      size_q    <= '0;
      pend_q    <= '0;
    end else begin
      live_q    <= live_d;
      started_q <= started_d;
      counted_q <= counted_d;
      size_q    <= size_d;
      if (cfg_start || push_fire)  remain_q <= remain_d;
      if (push_fire ^ ack_ok)      pend_q   <= pend_d;
    end
  end

  assign mem_size = size_q;
  assign done     = ended && (pend_q == '0);
endmodule

// File: rtl/swq_checker.sv
module swq_checker #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int DEPTH     = 8,
  parameter int PAGE_W    = 11,
  parameter int MAX_BURST = 256,
  parameter int CW        = 4,
  localparam int RW       = $clog2(MAX_BURST + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_last,
  input logic          push_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [CW-1:0] occ
);
  logic [RW-1:0]        run_q;
  logic [AW-PAGE_W-1:0] pg_q;
  logic                 hs;

  assign hs = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      pg_q  <= '0;
    end else if (hs) begin
      run_q <= mem_last ? '0 : run_q + 1'b1;
      pg_q  <= mem_addr[AW-1:PAGE_W];
    end
  end

  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> (run_q < RW'(MAX_BURST)));

  p_one_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && run_q != '0) |-> (mem_addr[AW-1:PAGE_W] == pg_q));

  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !push_ready);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_valid && occ == '0));
endmodule

bind stride_wr_queue swq_checker #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .PAGE_W(PAGE_W),
  .MAX_BURST(MAX_BURST), .CW(CW)
) u_swq_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_last(mem_last), .push_ready(push_ready), .done(done),
  .mem_addr(mem_addr), .mem_data(mem_data), .occ(buf_count)
);

// File: tb/stride_wr_queue_test.sv
module stride_wr_queue_test;
  localparam int AW = 32, DW = 64, LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_start, cfg_counted, stream_close, push_valid, mem_ready, mem_ack;
  logic [AW-1:0] cfg_base, cfg_stride;
  logic [1:0] cfg_size;
  logic [LEN_W-1:0] cfg_len;
  logic [DW-1:0] push_data;
  logic push_ready, mem_valid, mem_last, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [1:0] mem_size;

  logic [AW-1:0] cap_a [64];
  logic [DW-1:0] cap_d [64];
  logic          cap_l [64];
  logic          cap_dn [64];
  logic [1:0]    cap_s [64];
  int n_cap, n_chk, n_fail;
  bit hs_prev, finished;

  always #5 clk = ~clk;

  stride_wr_queue #(.DEPTH(8), .THRESH(6), .PAGE_W(8), .MAX_BURST(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .cfg_size(cfg_size), .cfg_counted(cfg_counted),
    .cfg_len(cfg_len), .stream_close(stream_close), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_size(mem_size), .mem_last(mem_last), .mem_ack(mem_ack), .done(done)
  );

  // memory model: record beats, acknowledge each one a cycle later
  initial begin
    n_cap = 0; mem_ack = 1'b0; hs_prev = 1'b0;
    forever begin
      @(negedge clk);
      mem_ack = hs_prev;
      hs_prev = 1'b0;
      if (rst_n && mem_valid && mem_ready) begin
        if (n_cap < 64) begin
          cap_a[n_cap] = mem_addr; cap_d[n_cap] = mem_data;
          cap_l[n_cap] = mem_last; cap_s[n_cap] = mem_size;
          cap_dn[n_cap] = done;
        end
        n_cap++;
        hs_prev = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input logic [31:0] b, input logic [31:0] s, input logic [1:0] z,
                     input bit cnt, input int len);
    cfg_base = b; cfg_stride = s; cfg_size = z; cfg_counted = cnt;
    cfg_len = LEN_W'(len); cfg_start = 1'b1;
    tick();
    cfg_start = 1'b0;
  endtask

  task automatic push(input logic [63:0] d);
    bit acc;
    push_valid = 1'b1; push_data = d; acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = push_ready;
      tick();
    end
    push_valid = 1'b0;
  endtask

  task automatic close_stream();
    stream_close = 1'b1; tick(); stream_close = 1'b0;
  endtask

  task automatic chk_beat(input int i, input logic [31:0] ea, input logic [63:0] ed,
                          input bit el, input logic [1:0] es);
    chk(cap_a[i] == ea, "R2 beat address", cap_a[i], ea);
    chk(cap_d[i] == ed, "R3 beat data order", cap_d[i], ed);
    chk(cap_l[i] == el, "R6 burst last marker", cap_l[i], el);
    chk(cap_s[i] == es, "R2 beat size code", cap_s[i], es);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(push_ready == 1'b0, "R1 push_ready after reset", push_ready, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    tick();
  endtask

  // word stream in one page: threshold, burst cap, close
  task automatic t_threshold();
    int b0;
    b0 = n_cap; mem_ready = 1'b1;
    cfg(32'h1000, 32'd1, 2'd1, 1'b0, 0);
    for (int k = 0; k < 5; k++) push(64'hA0 + k);
    repeat (10) tick();
    chk(n_cap == b0, "R4 no drain below threshold", n_cap - b0, 0);
    push(64'hA5);
    repeat (20) tick();
    chk(n_cap - b0 == 4, "R6 burst capped at MAX_BURST", n_cap - b0, 4);
    close_stream();
    @(negedge clk);
    chk(push_ready == 1'b0, "R9 close drops push_ready", push_ready, 0);
    repeat (20) tick();
    chk(n_cap - b0 == 6, "R9 close forces drain", n_cap - b0, 6);
    for (int k = 0; k < 6; k++)
      chk_beat(b0 + k, 32'h1000 + 4 * k, 64'hA0 + k, (k == 3) || (k == 5), 2'd1);
    chk(cap_dn[b0 + 5] == 1'b0, "R10 done low before final ack", cap_dn[b0 + 5], 0);
    chk(done == 1'b1, "R10 done after acks", done, 1);
  endtask

  // eight-byte elements crossing a page
  task automatic t_page();
    int b0;
    b0 = n_cap;
    cfg(32'h20E8, 32'd1, 2'd2, 1'b0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 new config clears done", done, 0);
    tick();
    push(64'hB0); push(64'hB1);
    repeat (10) tick();
    chk(n_cap == b0, "R5 no drain while next address in page", n_cap - b0, 0);
    push(64'hB2);
    repeat (10) tick();
    chk(n_cap - b0 == 3, "R5 page change starts drain", n_cap - b0, 3);
    push(64'hB3); push(64'hB4);
    repeat (10) tick();
    chk(n_cap - b0 == 3, "R4 two elements held", n_cap - b0, 3);
    close_stream();
    repeat (20) tick();
    chk(n_cap - b0 == 5, "R9 drain after close", n_cap - b0, 5);
    for (int k = 0; k < 5; k++)
      chk_beat(b0 + k, 32'h20E8 + 8 * k, 64'hB0 + k, (k == 2) || (k == 4), 2'd2);
    chk(done == 1'b1, "R10 done after acks", done, 1);
  endtask

  // counted byte stream with stride 3
  task automatic t_counted();
    int b0;
    b0 = n_cap;
    cfg(32'h3000, 32'd3, 2'd0, 1'b1, 4);
    for (int k = 0; k < 4; k++) push(64'hC0 + k);
    @(negedge clk);
    chk(push_ready == 1'b0, "R8 push_ready low after count", push_ready, 0);
    repeat (20) tick();
    chk(n_cap - b0 == 4, "R8 count end drains below threshold", n_cap - b0, 4);
    for (int k = 0; k < 4; k++)
      chk_beat(b0 + k, 32'h3000 + 3 * k, 64'hC0 + k, k == 3, 2'd0);
    chk(done == 1'b1, "R10 done after counted stream", done, 1);
  endtask

  // stalled memory, full buffer, page split inside the buffer
  task automatic t_backpressure();
    int b0;
    b0 = n_cap; mem_ready = 1'b0;
    cfg(32'h40F4, 32'd1, 2'd1, 1'b0, 0);
    for (int k = 0; k < 8; k++) push(64'hD0 + k);
    push_valid = 1'b1; push_data = 64'hDEAD;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(push_ready == 1'b0, "R7 full buffer refuses push", push_ready, 0);
      tick();
    end
    push_valid = 1'b0;
    close_stream();
    repeat (5) tick();
    chk(done == 1'b0, "R10 done low with unwritten elements", done, 0);
    chk(n_cap == b0, "R6 no beat while memory stalls", n_cap - b0, 0);
    mem_ready = 1'b1;
    repeat (30) tick();
    chk(n_cap - b0 == 8, "R7 refused push made no beat", n_cap - b0, 8);
    for (int k = 0; k < 8; k++)
      chk_beat(b0 + k, 32'h40F4 + 4 * k, 64'hD0 + k, (k == 2) || (k == 6) || (k == 7), 2'd1);
    chk(done == 1'b1, "R10 done after drain", done, 1);
  endtask

  initial begin
    finished = 1'b0;
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_start = 1'b0; cfg_base = '0; cfg_stride = '0; cfg_size = '0;
    cfg_counted = 1'b0; cfg_len = '0; stream_close = 1'b0; push_valid = 1'b0;
    push_data = '0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_threshold();
    t_page();
    t_counted();
    t_backpressure();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule